// File: doc/BRIEF.md
# SMBus Register Target with Alert Response

This block is a byte-oriented SMBus/I2C target that lets a bus host read and write a 64-entry register file kept outside the block. The host sends the target address with the write bit, then a byte that loads an internal register pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps forward. For a read, the host issues a repeated START with the read bit, and bytes are returned from the current pointer onward. The pointer never wraps. Writes beyond the last entry are acknowledged but dropped. Reads beyond it return zero.

The block also takes part in the SMBus alert protocol. When its alert input rises, an alert becomes pending. While the alert input is high and an alert is pending, the block answers a read of the Alert Response Address (7'b0001100). Its reply is a byte holding its own address in bits [7:1] with bit 0 cleared. If another device answers at the same time and drives a 0 where this block sends a 1, this block stops driving and keeps its alert pending. If it sends the whole byte without losing, the pending alert is cleared.

An SCL-low watchdog guards the bus. While a transaction is in progress, SCL held low for more than a programmed number of system clocks makes the block release SDA and return to idle. A disable input turns this watchdog off, and the transfer then continues wherever it stopped. The SCL and SDA inputs pass through a synchronizer and are sampled by the system clock.

Top module: `smb_regslave`

## Requirements
- R1: After a START, the block acknowledges an address byte whose bits [7:1] equal SLV_ADDR by pulling SDA low during the ninth clock. For any other address it leaves SDA released and does not respond again until the next START.
- R2: In a write, the first byte after the address loads the pointer with its low 6 bits. Each later byte is written to the register at the pointer with one reg_wr_o pulse, and the pointer then increments by one.
- R3: Once register 63 has been written, further write bytes in the same transfer are still acknowledged, but no reg_wr_o pulse occurs and no register is changed. The pointer does not wrap to 0.
- R4: After a repeated START with the read bit, bytes are sent MSB first, beginning at the current pointer. The pointer increments after each byte. After the byte at register 63 has been sent, every further byte in that transfer is 8'h00.
- R5: When the host NACKs a read byte, the block releases SDA and keeps it released until a STOP or START.
- R6: A read of address 7'b0001100 (byte 8'h19) is acknowledged only while alert_i is 1 and an alert is pending. The reply byte is {SLV_ADDR, 1'b0}. The same address with the write bit is not acknowledged.
- R7: Sending the full reply byte without losing arbitration clears the pending alert. Further alert reads are NACKed until alert_i rises again.
- R8: While sending, if the block releases SDA for a 1 and reads back a 0 at the SCL rising edge, it stops driving for the rest of the transfer. The pending alert stays set, so the next alert read is answered.
- R9: With tmo_dis_i at 0, if SCL stays low for more than TMO_CYCLES clocks during a transaction, SDA is released and the block waits for a new START.
- R10: With tmo_dis_i at 1, a long SCL-low period has no effect, and the transfer continues from the same bit.
- R11: After reset, SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| alert_i | input | 1 | Alert request level; a rising edge makes an alert pending |
| tmo_dis_i | input | 1 | 1 disables the SCL-low watchdog |
| sda_pd_o | output | 1 | Open-drain SDA pull-down enable |
| reg_addr_o | output | PTR_W | Register pointer, used for both reads and writes |
| reg_rd_o | output | 1 | One-cycle pulse when a register byte is fetched for sending |
| reg_rdata_i | input | 8 | Register data at reg_addr_o (read without delay) |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid while reg_wr_o is 1 |

## Verification
On every cycle, the assertions check several rules. SDA is pulled low only in an acknowledge slot or a send slot. An alert reply only starts while an alert is pending. No write strobe appears once the end-of-file latch is set. A lost arbitration leaves the line released. A watchdog expiry forces idle with SDA released. The watchdog never fires while disabled. Other behaviour can only be shown by the bench's bus scenarios: the actual byte values, the non-wrapping pointer and the zero fill after the last register, the alert being re-armed after a lost arbitration, and a stalled transfer resuming cleanly.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam logic [6:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RXD,
        ST_DACK,
        ST_TXD,
        ST_TACK,
        ST_WAIT
    } bus_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic [7:0] ara_reply(input logic [6:0] own);
        return {own, 1'b0};
    endfunction

endpackage

// File: rtl/smb_insync.sv
module smb_insync
    import smb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_chain, sda_chain;
    logic              scl_p, sda_p;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_chain[g] <= scl_i;
                    sda_chain[g] <= sda_i;
                end else begin
                    scl_chain[g] <= scl_chain[(g == 0) ? 0 : g-1];
                    sda_chain[g] <= sda_chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_chain[STAGES-1];
            sda_p <= sda_chain[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_chain[STAGES-1];
        ev.sda      = sda_chain[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_p;
        ev.scl_fall = ~ev.scl & scl_p;
        ev.start    = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop     = ev.scl & scl_p & ~sda_p & ev.sda;
    end
endmodule

// File: rtl/smb_tmo.sv
module smb_tmo #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);
    localparam logic [CW-1:0] CPRE = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            if (cnt != CMAX) cnt <= cnt + 1'b1;
            fire <= (cnt == CPRE);
        end
    end
endmodule

// File: rtl/smb_proto.sv
module smb_proto
    import smb_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h18,
    parameter int          PTR_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic             tmo_fire,
    input  logic             alert_i,
    input  logic [7:0]       reg_rdata,
    output logic             busy,
    output logic             sda_drv,
    output logic [PTR_W-1:0] ptr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [7:0]       reg_wdata
);
    localparam logic [PTR_W-1:0] LAST = {PTR_W{1'b1}};

    bus_state_e state;
    logic [3:0] bitc;
    logic [7:0] sh, tx_byte;
    logic       is_rd, is_ara, first, wover, rover, adv, ara_pend, alert_q;

    always_comb begin
        if (is_ara)     tx_byte = ara_reply(SLV_ADDR);
        else if (rover) tx_byte = 8'h00;
        else            tx_byte = reg_rdata;
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE; bitc <= '0; sh <= '0; sda_drv <= 1'b0;
            ptr <= '0; is_rd <= 1'b0; is_ara <= 1'b0; first <= 1'b0;
            wover <= 1'b0; rover <= 1'b0; adv <= 1'b0;
            ara_pend <= 1'b0; alert_q <= 1'b0;
            reg_rd <= 1'b0; reg_wr <= 1'b0; reg_wdata <= '0;
        end else begin
            reg_rd  <= 1'b0;
            reg_wr  <= 1'b0;
            alert_q <= alert_i;
            if (alert_i && !alert_q) ara_pend <= 1'b1;
            if (tmo_fire || ev.stop) begin
                state   <= ST_IDLE;
                sda_drv <= 1'b0;
            end else if (ev.start) begin
                state <= ST_ADDR; bitc <= '0; sda_drv <= 1'b0;
                wover <= 1'b0; rover <= 1'b0; adv <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RXD: begin
                        if (ev.scl_rise) begin
                            sh   <= {sh[6:0], ev.sda};
                            bitc <= bitc + 4'd1;
                        end else if (ev.scl_fall && bitc == 4'd8) begin
                            if (state == ST_RXD) begin
                                state   <= ST_DACK;
                                sda_drv <= 1'b1;
                                if (first) begin
                                    ptr   <= sh[PTR_W-1:0];
                                    first <= 1'b0;
                                end else if (!wover) begin
                                    reg_wr    <= 1'b1;
                                    reg_wdata <= sh;
                                    adv       <= 1'b1;
                                end
                            end else if (sh[7:1] == SLV_ADDR) begin
                                state <= ST_AACK; sda_drv <= 1'b1;
                                is_rd <= sh[0]; is_ara <= 1'b0; first <= ~sh[0];
                            end else if (sh == {ARA_ADDR, 1'b1} && alert_i && ara_pend) begin
                                state <= ST_AACK; sda_drv <= 1'b1;
                                is_rd <= 1'b1; is_ara <= 1'b1;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_AACK, ST_TACK: begin
                        if (state == ST_TACK && ev.scl_rise) begin
                            if (is_ara) begin
                                state <= ST_WAIT;
                            end else begin
                                if (ptr == LAST) rover <= 1'b1;
                                else             ptr   <= ptr + 1'b1;
                                if (ev.sda) state <= ST_WAIT;
                                else        bitc  <= 4'd9;
                            end
                        end else if (ev.scl_fall && (state == ST_AACK || bitc == 4'd9)) begin
                            bitc <= '0;
                            if (is_rd) begin
                                state   <= ST_TXD;
                                sh      <= tx_byte;
                                sda_drv <= ~tx_byte[7];
                                reg_rd  <= ~is_ara & ~rover;
                            end else begin
                                state   <= ST_RXD;
                                sda_drv <= 1'b0;
                            end
                        end
                    end
                    ST_DACK: begin
                        if (ev.scl_fall) begin
                            state <= ST_RXD; bitc <= '0; sda_drv <= 1'b0;
                            if (adv) begin
                                adv <= 1'b0;
                                if (ptr == LAST) wover <= 1'b1;
                                else             ptr   <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_TXD: begin
                        if (ev.scl_rise) begin
                            if (!sda_drv && !ev.sda) state <= ST_WAIT;
                            else                     bitc  <= bitc + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bitc == 4'd8) begin
                                state   <= ST_TACK;
                                sda_drv <= 1'b0;
                                if (is_ara) ara_pend <= 1'b0;
                            end else begin
                                sh      <= {sh[6:0], 1'b0};
                                sda_drv <= ~sh[6];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    drive_slot_chk: assert property (@(posedge clk) disable iff (rst)
        sda_drv |-> (state == ST_AACK || state == ST_DACK || state == ST_TXD));

    // R6
    ara_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AACK && is_ara) |-> ara_pend);

    // R3
    end_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        wover |=> !reg_wr);

    // R8
    arb_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TXD && ev.scl_rise && !sda_drv && !ev.sda && !tmo_fire)
        |=> (state == ST_WAIT && !sda_drv));

    // R9
    tmo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_fire |=> (state == ST_IDLE && !sda_drv));
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR   = 7'h18,
    parameter int          PTR_W      = 6,
    parameter int          TMO_CYCLES = 3_000_000,
    parameter int          SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             alert_i,
    input  logic             tmo_dis_i,
    output logic             sda_pd_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic             reg_rd_o,
    input  logic [7:0]       reg_rdata_i,
    output logic             reg_wr_o,
    output logic [7:0]       reg_wdata_o
);
    line_ev_t ev;
    logic     busy, tmo_run, tmo_fire;

    smb_insync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    assign tmo_run = busy & ~ev.scl & ~tmo_dis_i;

    smb_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst(rst), .run(tmo_run), .fire(tmo_fire)
    );

    smb_proto #(.SLV_ADDR(SLV_ADDR), .PTR_W(PTR_W)) u_proto (
        .clk(clk), .rst(rst), .ev(ev), .tmo_fire(tmo_fire),
        .alert_i(alert_i), .reg_rdata(reg_rdata_i), .busy(busy),
        .sda_drv(sda_pd_o), .ptr(reg_addr_o), .reg_rd(reg_rd_o),
        .reg_wr(reg_wr_o), .reg_wdata(reg_wdata_o)
    );

    // R10
    tmo_off_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_dis_i |=> !tmo_fire);
endmodule

// File: tb/smb_regslave_tb.sv
module smb_regslave_tb_top;
    localparam logic [6:0] SLV = 7'h18;
    localparam int TMO = 300;

    logic clk = 1'b0, rst = 1'b1;
    logic alert = 1'b0, tmo_dis = 1'b0;
    logic h_sda_low = 1'b0, h_scl_low = 1'b0, o_sda_low = 1'b0;
    logic sda_pd, reg_rd, reg_wr;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [64];
    logic [7:0] expm [64];
    logic [7:0] wbuf [8];
    int n_chk = 0, n_bad = 0;

    wire sda_line = !(h_sda_low | sda_pd | o_sda_low);
    wire scl_line = !h_scl_low;

    always #5 clk = ~clk;

    smb_regslave #(.SLV_ADDR(SLV), .PTR_W(6), .TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .alert_i(alert), .tmo_dis_i(tmo_dis), .sda_pd_o(sda_pd),
        .reg_addr_o(reg_addr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata),
        .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        h_sda_low = 1'b0; h_scl_low = 1'b0; q();
        h_sda_low = 1'b1; q();
        h_scl_low = 1'b1; q();
    endtask

    task automatic bus_rstart();
        h_sda_low = 1'b0; q();
        h_scl_low = 1'b0; q();
        h_sda_low = 1'b1; q();
        h_scl_low = 1'b1; q();
    endtask

    task automatic bus_stop();
        h_sda_low = 1'b1; q();
        h_scl_low = 1'b0; q();
        h_sda_low = 1'b0; q();
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            h_sda_low = !b[i]; q();
            h_scl_low = 1'b0; q(); q();
            h_scl_low = 1'b1; q();
        end
        h_sda_low = 1'b0;
    endtask

    task automatic get_ack(output bit ack);
        q();
        h_scl_low = 1'b0; q();
        ack = !sda_line; q();
        h_scl_low = 1'b1; q();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        send_bits(b);
        get_ack(ack);
    endtask

    task automatic rd_byte(input bit ack, input bit use_o, input logic [7:0] other,
                           output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            o_sda_low = use_o && !other[i]; q();
            h_scl_low = 1'b0; q();
            b[i] = sda_line; q();
            h_scl_low = 1'b1; q();
        end
        o_sda_low = 1'b0;
        h_sda_low = ack; q();
        h_scl_low = 1'b0; q(); q();
        h_scl_low = 1'b1; q();
        h_sda_low = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd(input int p, input int i);
        int  a = p;
        bit  ov = 0;
        for (int k = 0; k < i; k++) begin
            if (a == 63) ov = 1;
            else a++;
        end
        return ov ? 8'h00 : expm[a];
    endfunction

    task automatic model_wr(input int p, input int n);
        int a = p;
        bit ov = 0;
        for (int k = 0; k < n; k++) begin
            if (!ov) expm[a] = wbuf[k];
            if (a == 63) ov = 1;
            else a++;
        end
    endtask

    task automatic wr_seq(input logic [7:0] pbyte, input int n, input string tag);
        bit ack;
        bus_start();
        wr_byte({SLV, 1'b0}, ack);
        chk(ack, "R1 own address ack", ack, 1);
        wr_byte(pbyte, ack);
        chk(ack, "R2 pointer byte ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], ack);
            chk(ack, tag, ack, 1);
        end
        bus_stop();
        model_wr(int'(pbyte[5:0]), n);
    endtask

    task automatic rd_seq(input int p, input int n, input string tag);
        bit ack;
        logic [7:0] b;
        bus_start();
        wr_byte({SLV, 1'b0}, ack);
        wr_byte(8'(p), ack);
        bus_rstart();
        wr_byte({SLV, 1'b1}, ack);
        chk(ack, "R4 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, 1'b0, 8'h00, b);
            chk(b == exp_rd(p, k), tag, b, exp_rd(p, k));
        end
        rd_byte(1'b0, 1'b0, 8'h00, b);
        chk(b == 8'hFF, "R5 silent after host NACK", b, 8'hFF);
        bus_stop();
    endtask

    initial begin
        repeat (380000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int unsigned sd;
        sd = $urandom(32'h5eed);
        for (int i = 0; i < 64; i++) expm[i] = 8'(i * 7 + 3);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        q();
        chk(sda_pd == 1'b0, "R11 SDA released after reset", sda_pd, 0);

        // R11: pointer is 0 after reset
        bus_start();
        wr_byte({SLV, 1'b1}, ack);
        chk(ack, "R11 read ack", ack, 1);
        rd_byte(1'b0, 1'b0, 8'h00, b);
        chk(b == expm[0], "R11 read from pointer 0", b, expm[0]);
        bus_stop();

        // R1: foreign address
        bus_start();
        wr_byte({SLV ^ 7'h01, 1'b0}, ack);
        chk(!ack, "R1 foreign address NACK", ack, 0);
        send_bits(8'h00); get_ack(ack);
        chk(!ack, "R1 silent until next START", ack, 0);
        bus_stop();

        // R2: pointer byte keeps low 6 bits
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        wr_seq(8'hC5, 3, "R2 data ack");
        rd_seq(5, 3, "R2 readback");

        // R3 / R4: past the end
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_seq(8'd62, 4, "R3 ack past end");
        rd_seq(62, 4, "R4 readback past end");
        rd_seq(0, 2, "R3 no wrap to 0");

        // R6: alert low
        bus_start();
        wr_byte(8'h19, ack);
        chk(!ack, "R6 ARA NACK without alert", ack, 0);
        bus_stop();
        alert = 1'b1; q();
        bus_start();
        wr_byte(8'h18, ack);
        chk(!ack, "R6 ARA write bit NACK", ack, 0);
        bus_stop();
        bus_start();
        wr_byte(8'h19, ack);
        chk(ack, "R6 ARA ack", ack, 1);
        rd_byte(1'b0, 1'b0, 8'h00, b);
        chk(b == {SLV, 1'b0}, "R6 ARA reply", b, {SLV, 1'b0});
        bus_stop();
        // R7: cleared after win
        bus_start();
        wr_byte(8'h19, ack);
        chk(!ack, "R7 ARA NACK after win", ack, 0);
        bus_stop();

        // R8: lose to lower address 7'h10
        alert = 1'b0; q(); alert = 1'b1; q();
        bus_start();
        wr_byte(8'h19, ack);
        chk(ack, "R8 ARA ack before arbitration", ack, 1);
        rd_byte(1'b0, 1'b1, 8'h20, b);
        chk(b == 8'h20, "R8 winner byte on bus", b, 8'h20);
        chk(sda_pd == 1'b0, "R8 released after loss", sda_pd, 0);
        bus_stop();
        bus_start();
        wr_byte(8'h19, ack);
        chk(ack, "R8 pending kept after loss", ack, 1);
        rd_byte(1'b0, 1'b0, 8'h00, b);
        chk(b == {SLV, 1'b0}, "R8 reply after loss", b, {SLV, 1'b0});
        bus_stop();
        alert = 1'b0;

        // R9: timeout enabled
        bus_start();
        send_bits({SLV, 1'b0});
        q();
        chk(sda_pd == 1'b1, "R9 driving ack before stall", sda_pd, 1);
        repeat (2 * TMO) @(negedge clk);
        chk(sda_pd == 1'b0, "R9 released after timeout", sda_pd, 0);
        bus_stop();
        wbuf[0] = 8'h5C;
        wr_seq(8'd20, 1, "R9 recovery write");
        rd_seq(20, 1, "R9 recovery readback");

        // R10: timeout disabled
        tmo_dis = 1'b1;
        bus_start();
        send_bits({SLV, 1'b0});
        repeat (2 * TMO) @(negedge clk);
        chk(sda_pd == 1'b1, "R10 still driving ack", sda_pd, 1);
        get_ack(ack);
        chk(ack, "R10 ack after stall", ack, 1);
        wr_byte(8'd30, ack);
        wr_byte(8'hE7, ack);
        chk(ack, "R10 data ack", ack, 1);
        bus_stop();
        wbuf[0] = 8'hE7; model_wr(30, 1);
        tmo_dis = 1'b0;
        rd_seq(30, 1, "R10 transfer resumed");

        // random traffic
        for (int it = 0; it < 10; it++) begin
            int p, n;
            p = int'($urandom % 64);
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            wr_seq(8'(p), n, "R2 random write ack");
            rd_seq(p, n, "R4 random readback");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule